// File: doc/BRIEF.md
# Audio Receive Channel Adapter FIFO

This block takes playback audio frames from a valid/ready stream, converts each sample to the 24-bit width of the output stage, and reshapes the channel count to what that stage consumes. The stream can carry one or two channels per frame, and each input sample is 16 or 32 bits wide. A mono stream can be widened to stereo in one of two ways: the second side is filled with zero, or the single sample is copied to both sides. A stereo stream can be reduced to mono in one of three ways: channel 0 is kept, channel 1 is kept, or the two channels are averaged. Converted frames are stored in a receive FIFO. The downstream consumer drains that FIFO through its own valid/ready pair.

All configuration arrives on static input ports. These ports are expected to change only while the FIFO is empty. A request flag tells the consumer that more frames are stored than a programmable threshold. The threshold is counted in frames and is clamped to a legal maximum. A sticky overflow flag records any attempt to write while the FIFO is full.

Top module: `arx_adapt_fifo`

## Requirements
- R1: With `cfg_in_w32_i`=0, an input sample contributes its bits [15:0] as the upper 16 bits of the 24-bit sample, and the lower 8 bits are zero. Input bits [31:16] are ignored.
- R2: With `cfg_in_w32_i`=1, the 24-bit sample is input bits [31:8].
- R3: For a stereo input (`cfg_in_ch2_i`=1) and a stereo output (`cfg_client_i`=2 or 3), channel 0 goes to `out_left_o` and channel 1 goes to `out_right_o`.
- R4: For a mono input and a stereo output, channel 0 goes to `out_left_o`. `out_right_o` is zero when `cfg_widen_i`=0 and equals channel 0 when `cfg_widen_i`=1. `in_ch1_i` is ignored.
- R5: For a stereo input and a mono output, `cfg_narrow_i`=0 selects channel 0 and `cfg_narrow_i`=1 selects channel 1. The code 3 behaves like 0.
- R6: With `cfg_narrow_i`=2, the mono sample is the sign-extended sum of both 24-bit samples shifted arithmetically right by one. This rounds toward minus infinity and never wraps.
- R7: `cfg_client_i`=0 places the mono sample on `out_left_o` with `out_right_o` zero. `cfg_client_i`=1 places it on `out_right_o` with `out_left_o` zero. For a mono input, the mono sample is channel 0.
- R8: Frames leave in the order they were accepted. The FIFO holds DEPTH frames for a mono output and DEPTH/2 frames for a stereo output. `in_ready_o` is low exactly while that capacity is reached.
- R9: `req_o` is high exactly while the number of stored frames exceeds the effective threshold.
- R10: The effective threshold is `cfg_thresh_i`, limited to (DEPTH / input channel count) - 1.
- R11: `in_valid_i` high while `in_ready_o` is low sets `ovf_o`. `ovf_o` then stays high until reset.
- R12: After reset the FIFO is empty: `out_valid_o`=0, `req_o`=0, `ovf_o`=0 and `in_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_in_ch2_i | input | 1 | Input frames carry two channels |
| cfg_in_w32_i | input | 1 | Input samples are 32 bits (else 16) |
| cfg_client_i | input | 2 | Output layout: 0 left only, 1 right only, 2/3 stereo |
| cfg_widen_i | input | 1 | Mono-to-stereo fill: 0 zero, 1 copy |
| cfg_narrow_i | input | 2 | Stereo-to-mono: 0 ch0, 1 ch1, 2 average, 3 ch0 |
| cfg_thresh_i | input | $clog2(DEPTH) | Request threshold in frames |
| in_valid_i | input | 1 | Input frame valid |
| in_ready_o | output | 1 | FIFO can accept a frame |
| in_ch0_i | input | 32 | Channel 0 sample |
| in_ch1_i | input | 32 | Channel 1 sample |
| out_valid_o | output | 1 | A stored frame is available |
| out_ready_i | input | 1 | Consumer takes the frame |
| out_left_o | output | 24 | Left output sample |
| out_right_o | output | 24 | Right output sample |
| req_o | output | 1 | Stored frames exceed the threshold |
| ovf_o | output | 1 | Sticky write-while-full flag |

## Verification
The properties assume that the configuration ports stay fixed whenever frames are stored. If they did not, the frame capacity could move under a full FIFO. The bench therefore changes configuration only right after a reset or after draining the FIFO. Overflow is provoked on purpose, by holding `in_valid_i` high against a full FIFO for a single cycle. Each stream handshake is driven and sampled on the falling clock edge, so that every ready and level change comes from one rising edge only.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int SMP_W = 24;
  localparam int RAW_W = 32;

  typedef logic [SMP_W-1:0] smp_t;

  typedef struct packed {
    smp_t left;
    smp_t right;
  } frame_t;

  localparam logic [1:0] CLI_LEFT  = 2'd0;
  localparam logic [1:0] CLI_RIGHT = 2'd1;

  localparam logic [1:0] NAR_CH1 = 2'd1;
  localparam logic [1:0] NAR_AVG = 2'd2;
endpackage

// File: rtl/arx_sample_conv.sv
module arx_sample_conv
  import arx_pkg::*;
(
  input  logic [RAW_W-1:0] raw_i,
  input  logic             w32_i,
  output smp_t             smp_o
);
  // 16-bit input is left-justified; 32-bit input keeps its top bits
  always_comb begin
    if (w32_i) smp_o = raw_i[RAW_W-1 -: SMP_W];
    else       smp_o = {raw_i[15:0], 8'h00};
  end
endmodule

// File: rtl/arx_chan_adapt.sv
module arx_chan_adapt
  import arx_pkg::*;
(
  input  smp_t       s0_i,
  input  smp_t       s1_i,
  input  logic       in_ch2_i,
  input  logic [1:0] client_i,
  input  logic       widen_i,
  input  logic [1:0] narrow_i,
  output frame_t     frame_o
);
  logic signed [SMP_W:0] sum;
  smp_t avg, mono;

  always_comb begin
    sum  = $signed({s0_i[SMP_W-1], s0_i}) + $signed({s1_i[SMP_W-1], s1_i});
    avg  = sum[SMP_W:1];
    mono = s0_i;
    if (in_ch2_i) begin
      if (narrow_i == NAR_CH1)      mono = s1_i;
      else if (narrow_i == NAR_AVG) mono = avg;
    end
  end

  always_comb begin
    if (client_i == CLI_LEFT) begin
      frame_o = '{left: mono, right: '0};
    end else if (client_i == CLI_RIGHT) begin
      frame_o = '{left: '0, right: mono};
    end else if (in_ch2_i) begin
      frame_o = '{left: s0_i, right: s1_i};
    end else begin
      frame_o = '{left: s0_i, right: (widen_i ? s0_i : '0)};
    end
  end
endmodule

// File: rtl/arx_frame_fifo.sv
module arx_frame_fifo
  import arx_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1,
  localparam int TW    = AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_cap_i,
  input  logic          in_ch2_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  frame_t        wr_frame_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output frame_t        rd_frame_o,
  output logic          req_o,
  output logic          ovf_o,
  output logic [CW-1:0] level_o
);
  frame_t        mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level, cap;
  logic [TW-1:0] max_th, eff_th;
  logic          push, pop;

  assign cap        = half_cap_i ? CW'(DEPTH / 2) : CW'(DEPTH);
  assign wr_ready_o = level < cap;
  assign rd_valid_o = level != '0;
  assign push       = wr_valid_i && wr_ready_o;
  assign pop        = rd_valid_o && rd_ready_i;
  assign rd_frame_o = mem[rd_ptr];
  assign level_o    = level;

  // threshold ceiling follows the input channel count
  assign max_th = in_ch2_i ? TW'(DEPTH / 2 - 1) : TW'(DEPTH - 1);
  assign eff_th = (thresh_i > max_th) ? max_th : thresh_i;
  assign req_o  = level > {1'b0, eff_th};

  always_ff @(posedge clk_i) begin
    if (push) mem[wr_ptr] <= wr_frame_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      level <= level + CW'(push) - CW'(pop);
      if (wr_valid_i && !wr_ready_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/arx_adapt_fifo.sv
module arx_adapt_fifo
  import arx_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int TW    = $clog2(DEPTH),
  localparam int CW    = TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_in_ch2_i,
  input  logic          cfg_in_w32_i,
  input  logic [1:0]    cfg_client_i,
  input  logic          cfg_widen_i,
  input  logic [1:0]    cfg_narrow_i,
  input  logic [TW-1:0] cfg_thresh_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [31:0]   in_ch0_i,
  input  logic [31:0]   in_ch1_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [23:0]   out_left_o,
  output logic [23:0]   out_right_o,
  output logic          req_o,
  output logic          ovf_o
);
  smp_t          smp [2];
  logic [31:0]   raw [2];
  frame_t        wr_frame, rd_frame;
  logic [CW-1:0] fill_cnt;

  assign raw[0] = in_ch0_i;
  assign raw[1] = in_ch1_i;

  for (genvar g = 0; g < 2; g++) begin : g_conv
    arx_sample_conv u_conv (
      .raw_i (raw[g]),
      .w32_i (cfg_in_w32_i),
      .smp_o (smp[g])
    );
  end

  arx_chan_adapt u_adapt (
    .s0_i     (smp[0]),
    .s1_i     (smp[1]),
    .in_ch2_i (cfg_in_ch2_i),
    .client_i (cfg_client_i),
    .widen_i  (cfg_widen_i),
    .narrow_i (cfg_narrow_i),
    .frame_o  (wr_frame)
  );

  arx_frame_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_cap_i (cfg_client_i[1]),
    .in_ch2_i   (cfg_in_ch2_i),
    .thresh_i   (cfg_thresh_i),
    .wr_valid_i (in_valid_i),
    .wr_ready_o (in_ready_o),
    .wr_frame_i (wr_frame),
    .rd_valid_o (out_valid_o),
    .rd_ready_i (out_ready_i),
    .rd_frame_o (rd_frame),
    .req_o      (req_o),
    .ovf_o      (ovf_o),
    .level_o    (fill_cnt)
  );

  assign out_left_o  = rd_frame.left;
  assign out_right_o = rd_frame.right;
endmodule

// File: rtl/arx_adapt_fifo_chk.sv
module arx_adapt_fifo_chk #(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    cfg_client_i,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic          req_o,
  input logic          ovf_o,
  input logic [CW-1:0] fill_cnt_i
);
  logic [CW-1:0] cap;
  logic          push, pop;

  assign cap  = cfg_client_i[1] ? CW'(DEPTH / 2) : CW'(DEPTH);
  assign push = in_valid_i && in_ready_o;
  assign pop  = out_valid_o && out_ready_i;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cnt_i <= cap); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_cnt_i == cap) |-> !in_ready_o); // R8
  AST_LEVEL_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop) |=> (fill_cnt_i == $past(fill_cnt_i) + 1'b1)); // R8
  AST_REQ_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> out_valid_o); // R9
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> ovf_o); // R11
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R11
endmodule

bind arx_adapt_fifo arx_adapt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_client_i (cfg_client_i),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .req_o        (req_o),
  .ovf_o        (ovf_o),
  .fill_cnt_i   (fill_cnt)
);

// File: tb/sim_arx_adapt_fifo.sv
module sim_arx_adapt_fifo;
  localparam int DEPTH = 64;
  localparam int TW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_ch2 = 1'b1, in_w32 = 1'b1, widen = 1'b0;
  logic [1:0] client = 2'd2, narrow = 2'd0;
  logic [TW-1:0] thresh = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] ch0 = '0, ch1 = '0;
  logic in_ready, out_valid, req, ovf;
  logic [23:0] out_l, out_r;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  arx_adapt_fifo #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_in_ch2_i(in_ch2), .cfg_in_w32_i(in_w32), .cfg_client_i(client),
    .cfg_widen_i(widen), .cfg_narrow_i(narrow), .cfg_thresh_i(thresh),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_ch0_i(ch0), .in_ch1_i(ch1),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_left_o(out_l), .out_right_o(out_r),
    .req_o(req), .ovf_o(ovf)
  );

  task automatic chk(input string r, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    ch0 = a; ch1 = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take(input string r, input logic [23:0] el, input logic [23:0] er);
    @(negedge clk);
    chk({r, " valid"}, 48'(out_valid), 48'd1);
    chk(r, {out_l, out_r}, {el, er});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 out_valid", 48'(out_valid), 48'd0);
    chk("R12 req", 48'(req), 48'd0);
    chk("R12 ovf", 48'(ovf), 48'd0);
    chk("R12 in_ready", 48'(in_ready), 48'd1);
  endtask

  task automatic t_width();
    in_ch2 = 1; client = 2; in_w32 = 0;
    send(32'hABCD_1234, 32'hFFFF_8001);
    take("R1 R3 16-bit stereo", 24'h123400, 24'h800100);
    in_w32 = 1;
    send(32'h89AB_CDEF, 32'h0123_4567);
    take("R2 R3 32-bit stereo", 24'h89ABCD, 24'h012345);
  endtask

  task automatic t_widen();
    in_ch2 = 0; client = 2; in_w32 = 0; widen = 0;
    send(32'h0000_1111, 32'h0000_7777);
    take("R4 widen zero", 24'h111100, 24'h000000);
    widen = 1;
    send(32'h0000_2222, 32'h0000_7777);
    take("R4 widen copy", 24'h222200, 24'h222200);
  endtask

  task automatic t_narrow();
    in_ch2 = 1; in_w32 = 1; client = 0;
    narrow = 0; send(32'h1111_1100, 32'h2222_2200);
    take("R5 narrow ch0", 24'h111111, 24'h0);
    narrow = 1; send(32'h1111_1100, 32'h2222_2200);
    take("R5 narrow ch1", 24'h222222, 24'h0);
    narrow = 3; send(32'h1111_1100, 32'h2222_2200);
    take("R5 narrow code3", 24'h111111, 24'h0);
    client = 1; narrow = 0; send(32'h3333_3300, 32'h4444_4400);
    take("R7 right only", 24'h0, 24'h333333);
    in_ch2 = 0; client = 0; send(32'h5555_5500, 32'h6666_6600);
    take("R7 mono to left", 24'h555555, 24'h0);
  endtask

  task automatic t_avg();
    in_ch2 = 1; in_w32 = 1; client = 0; narrow = 2;
    send(32'h0000_0400, 32'h0000_0A00);
    take("R6 avg positive", 24'h000007, 24'h0);
    send(32'hFFFF_FF00, 32'h0000_0000);
    take("R6 avg floor", 24'hFFFFFF, 24'h0);
    send(32'h7FFF_FF00, 32'h7FFF_FF00);
    take("R6 avg max", 24'h7FFFFF, 24'h0);
    send(32'h8000_0000, 32'h8000_0000);
    take("R6 avg min", 24'h800000, 24'h0);
    send(32'h7FFF_FF00, 32'h8000_0000);
    take("R6 avg mixed", 24'hFFFFFF, 24'h0);
    narrow = 0;
  endtask

  task automatic t_fill();
    do_reset();
    in_ch2 = 1; in_w32 = 1; client = 2; thresh = 5;
    for (int i = 0; i < DEPTH / 2; i++) begin
      send(32'(i) << 8, 32'(i + 100) << 8);
      chk($sformatf("R9 req after %0d", i + 1), 48'(req), 48'(i + 1 > 5));
    end
    chk("R8 full stereo", 48'(in_ready), 48'd0);
    send(32'hDEAD_BE00, 32'hDEAD_BE00);
    chk("R11 ovf set", 48'(ovf), 48'd1);
    for (int i = 0; i < DEPTH / 2; i++)
      take("R8 order", 24'(i), 24'(i + 100));
    chk("R8 drained", 48'(out_valid), 48'd0);
    chk("R11 ovf held", 48'(ovf), 48'd1);
    chk("R9 req empty", 48'(req), 48'd0);
  endtask

  task automatic t_clamp();
    do_reset();
    in_ch2 = 1; client = 0; narrow = 0; thresh = 50;
    for (int i = 0; i < 31; i++) send(32'(i) << 8, 32'h0);
    chk("R10 clamp below", 48'(req), 48'd0);
    send(32'h0, 32'h0);
    chk("R10 clamp reached", 48'(req), 48'd1);
    for (int i = 32; i < DEPTH; i++) send(32'h0, 32'h0);
    chk("R8 full mono", 48'(in_ready), 48'd0);
    do_reset();
    in_ch2 = 0;
    for (int i = 0; i < 50; i++) send(32'h0, 32'h0);
    chk("R10 mono thresh below", 48'(req), 48'd0);
    send(32'h0, 32'h0);
    chk("R10 mono thresh above", 48'(req), 48'd1);
    chk("R8 not full", 48'(in_ready), 48'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_width();
    t_widen();
    t_narrow();
    t_avg();
    t_fill();
    t_clamp();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule